// File: doc/BRIEF.md
# CD Sector Sync Framer

This block sits on the raw byte stream that comes off a CD-ROM drive. It keeps track of where each 2352-byte sector starts. It looks for the twelve-byte sync pattern: one zero byte, ten 0xFF bytes, then a final zero byte. It keeps a 12-bit byte position inside the current sector. When sync insertion is switched on, it can also close a sector by itself at the expected position. Each boundary is classified as clean, misplaced (illegal), inserted without sync (missing), long or short.

In monitor mode, the four bytes that follow a boundary are taken as the sector header: minute, second, frame and mode. When decoding is enabled, a programmable delay after the boundary ends the decode. At that point the header is checked against BCD ranges and the sync flags, and a pass or fail result is published. An active-low interrupt then tells the host that the decode is done.

Top module: `cd_sync_framer`

## Requirements
- R1: A boundary is detected when all of the following hold on one valid byte: the byte is 0x00, the previous eleven valid bytes were 0x00 followed by ten 0xFF, and the current byte position has its two low bits equal to 11b. The position then restarts, so the next valid byte is at position 0.
- R2: With `sync_ins_en_i` high, a valid byte at position 2351 is a boundary whether or not it completes a sync pattern.
- R3: A boundary that comes only from insertion, where the byte neither completed an aligned sync nor a misaligned one, sets `no_sync_o`.
- R4: A detected sync at any position other than 2351 sets `ill_sync_o`.
- R5: When a valid byte is not a boundary, two flags can be set. A sync pattern completed at an unaligned position sets `short_blk_o`. A byte at position 2351 sets `long_blk_o`.
- R6: Every boundary clears all of the following on the next edge and releases `dec_irq_no` to 1:
  - the long and short flags;
  - `crc_ok_o`, `unc_blk_o` and `word_long_o`.
  At the same boundary, the sync flags are reloaded for the new sector.
- R7: Each non-boundary valid byte advances the position by one, wrapping from 4095 to 0. Cycles with `byte_vld_i` low change nothing.
- R8: With `dec_en_i` high and `wr_req_i` low, a valid byte at positions 0 to 3 is stored into the minute, second, frame and mode registers respectively. Otherwise the header registers hold their value.
- R9: The header passes only when all of the following hold:
  - minute < 0x74, second < 0x60 and frame < 0x75, each with a low nibble below 0xA;
  - mode < 3;
  - neither `no_sync_o` nor `ill_sync_o` is set.
- R10: When the header passes, the result is status pair 0x00/0x90. When it fails, the result is 0xFF/0xF2. `crc_ok_o` (pass) or `unc_blk_o` (fail) is set only if `rpt_en_i` is high.
- R11: A boundary with `dec_en_i` high ends decoding exactly DEC_DELAY cycles later, unless another boundary comes first. At that point `word_long_o` is set and `dec_irq_no` goes low. A boundary with `dec_en_i` low starts no decode.
- R12: `irq_ack_i` releases `dec_irq_no` on the next edge, except in a cycle where decode completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Stream byte |
| byte_vld_i | input | 1 | Byte strobe |
| dec_en_i | input | 1 | Decoder enable |
| wr_req_i | input | 1 | Buffer write request (disables header capture) |
| sync_ins_en_i | input | 1 | Sync insertion enable |
| rpt_en_i | input | 1 | Allow pass/fail flag reporting |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| hdr_min_o | output | 8 | Header minute |
| hdr_sec_o | output | 8 | Header second |
| hdr_frm_o | output | 8 | Header frame |
| hdr_mode_o | output | 8 | Header mode |
| ill_sync_o | output | 1 | Misplaced sync |
| no_sync_o | output | 1 | Boundary inserted without sync |
| long_blk_o | output | 1 | Sector overran its length |
| short_blk_o | output | 1 | Unaligned sync seen |
| crc_ok_o | output | 1 | Header passed |
| unc_blk_o | output | 1 | Header failed |
| word_long_o | output | 1 | Decode completed |
| err_stat_o | output | 8 | Error status (0x00 / 0xFF) |
| dec_stat_o | output | 8 | Decode status (0x90 / 0xF2) |
| dec_irq_no | output | 1 | Decode-done interrupt, active low |

## Verification
The effects of a byte, both the flags and the header capture, appear on the clock edge that samples that byte. Decode results appear DEC_DELAY edges after the boundary edge, and an acknowledge takes effect one edge after it is sampled. A behavioural model in the bench advances on the same rising edge as the design. Every output is compared with the model at the following falling edge, so both one-edge and delayed results are checked in the exact cycle they are due. The stimulus covers several conditions:
- aligned, misplaced, unaligned and missing syncs;
- a 4096-byte overrun to exercise the position wrap;
- header values on both sides of every range limit.

// File: rtl/cdsf_pkg.sv
package cdsf_pkg;
  localparam int SYNC_LEN = 12;
  localparam logic [7:0] PASS_ERR = 8'h00;
  localparam logic [7:0] PASS_DEC = 8'h90;
  localparam logic [7:0] FAIL_ERR = 8'hFF;
  localparam logic [7:0] FAIL_DEC = 8'hF2;

  typedef struct packed {
    logic ill_sync;
    logic no_sync;
    logic long_blk;
    logic short_blk;
  } frm_flags_t;

  function automatic logic [7:0] sync_byte(input int idx);
    return (idx == 0 || idx == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic bcd_below(input logic [7:0] v, input logic [7:0] lim);
    return (v < lim) && (v[3:0] < 4'hA);
  endfunction
endpackage

// File: rtl/cdsf_sync_det.sv
module cdsf_sync_det
  import cdsf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       vld_i,
  input  logic       aligned_i,
  output logic       det_o,
  output logic       ign_o
);
  localparam int MW = $clog2(SYNC_LEN);
  localparam logic [MW-1:0] FULL = MW'(SYNC_LEN - 1);

  logic [MW-1:0] mcnt_q;
  logic          hit, match;

  assign hit   = (byte_i == sync_byte(int'(mcnt_q)));
  assign match = vld_i && (mcnt_q == FULL) && (byte_i == 8'h00);
  assign det_o = match && aligned_i;
  assign ign_o = match && !aligned_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= '0;
    end else if (vld_i) begin
      if (hit)                 mcnt_q <= (mcnt_q == FULL) ? MW'(1) : mcnt_q + MW'(1);
      else if (byte_i == 8'h00) mcnt_q <= MW'(1);
      else                     mcnt_q <= '0;
    end
  end
endmodule

// File: rtl/cdsf_sector_cnt.sv
module cdsf_sector_cnt
  import cdsf_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SECT_LAST = 2351
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             det_i,
  input  logic             ign_i,
  input  logic             ins_en_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             bnd_o,
  output frm_flags_t       flags_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SECT_LAST);

  logic [CNT_W-1:0] pos_q;
  frm_flags_t       flags_q;
  logic             ins;

  assign ins     = ins_en_i && (pos_q == LAST);
  assign bnd_o   = vld_i && (det_i || ins);
  assign pos_o   = pos_q;
  assign flags_o = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      flags_q <= '0;
    end else if (bnd_o) begin
      pos_q              <= '0;
      flags_q.ill_sync   <= det_i && (pos_q != LAST);
      flags_q.no_sync    <= ins && !det_i && !ign_i;
      flags_q.long_blk   <= 1'b0;
      flags_q.short_blk  <= 1'b0;
    end else if (vld_i) begin
      pos_q <= pos_q + CNT_W'(1);
      if (ign_i)         flags_q.short_blk <= 1'b1;
      if (pos_q == LAST) flags_q.long_blk  <= 1'b1;
    end
  end
endmodule

// File: rtl/cdsf_hdr_dec.sv
module cdsf_hdr_dec
  import cdsf_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DEC_DELAY = 22030
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic             bnd_i,
  input  logic             dec_en_i,
  input  logic             wr_req_i,
  input  logic             rpt_en_i,
  input  logic             irq_ack_i,
  input  frm_flags_t       flags_i,
  output logic [3:0][7:0]  hdr_o,
  output logic             crc_ok_o,
  output logic             unc_blk_o,
  output logic             word_long_o,
  output logic [7:0]       err_stat_o,
  output logic [7:0]       dec_stat_o,
  output logic             irq_no,
  output logic             done_o
);
  localparam int TW = $clog2(DEC_DELAY + 1);
  localparam logic [TW-1:0] DLY = TW'(DEC_DELAY);

  logic [3:0][7:0] hdr_q;
  logic [TW-1:0]   tmr_q;
  logic            cap_en, pass;

  assign cap_en = vld_i && dec_en_i && !wr_req_i && (pos_i < CNT_W'(4));
  assign done_o = !bnd_i && (tmr_q == TW'(1));
  assign pass   = bcd_below(hdr_q[0], 8'h74) && bcd_below(hdr_q[1], 8'h60) &&
                  bcd_below(hdr_q[2], 8'h75) && (hdr_q[3] < 8'd3) &&
                  !flags_i.no_sync && !flags_i.ill_sync;
  assign hdr_o  = hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q       <= '0;
      tmr_q       <= '0;
      crc_ok_o    <= 1'b0;
      unc_blk_o   <= 1'b0;
      word_long_o <= 1'b0;
      err_stat_o  <= '0;
      dec_stat_o  <= '0;
      irq_no      <= 1'b1;
    end else begin
      if (cap_en) hdr_q[pos_i[1:0]] <= byte_i;
      if (bnd_i) begin
        tmr_q       <= dec_en_i ? DLY : '0;
        crc_ok_o    <= 1'b0;
        unc_blk_o   <= 1'b0;
        word_long_o <= 1'b0;
        irq_no      <= 1'b1;
      end else begin
        if (tmr_q != '0) tmr_q <= tmr_q - TW'(1);
        if (done_o) begin
          err_stat_o  <= pass ? PASS_ERR : FAIL_ERR;
          dec_stat_o  <= pass ? PASS_DEC : FAIL_DEC;
          if (rpt_en_i) begin
            if (pass) crc_ok_o  <= 1'b1;
            else      unc_blk_o <= 1'b1;
          end
          word_long_o <= 1'b1;
          irq_no      <= 1'b0;
        end else if (irq_ack_i) begin
          irq_no <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cd_sync_framer.sv
module cd_sync_framer
  import cdsf_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SECT_LAST = 2351,
  parameter int DEC_DELAY = 22030
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  input  logic       dec_en_i,
  input  logic       wr_req_i,
  input  logic       sync_ins_en_i,
  input  logic       rpt_en_i,
  input  logic       irq_ack_i,
  output logic [7:0] hdr_min_o,
  output logic [7:0] hdr_sec_o,
  output logic [7:0] hdr_frm_o,
  output logic [7:0] hdr_mode_o,
  output logic       ill_sync_o,
  output logic       no_sync_o,
  output logic       long_blk_o,
  output logic       short_blk_o,
  output logic       crc_ok_o,
  output logic       unc_blk_o,
  output logic       word_long_o,
  output logic [7:0] err_stat_o,
  output logic [7:0] dec_stat_o,
  output logic       dec_irq_no
);
  logic [CNT_W-1:0] pos;
  logic             det, ign, bnd, dec_done;
  frm_flags_t       flags;
  logic [3:0][7:0]  hdr;

  cdsf_sync_det u_sync (
    .clk_i, .rst_ni, .byte_i, .vld_i(byte_vld_i),
    .aligned_i(pos[1:0] == 2'b11), .det_o(det), .ign_o(ign)
  );

  cdsf_sector_cnt #(.CNT_W(CNT_W), .SECT_LAST(SECT_LAST)) u_cnt (
    .clk_i, .rst_ni, .vld_i(byte_vld_i), .det_i(det), .ign_i(ign),
    .ins_en_i(sync_ins_en_i), .pos_o(pos), .bnd_o(bnd), .flags_o(flags)
  );

  cdsf_hdr_dec #(.CNT_W(CNT_W), .DEC_DELAY(DEC_DELAY)) u_dec (
    .clk_i, .rst_ni, .byte_i, .vld_i(byte_vld_i), .pos_i(pos), .bnd_i(bnd),
    .dec_en_i, .wr_req_i, .rpt_en_i, .irq_ack_i, .flags_i(flags),
    .hdr_o(hdr), .crc_ok_o, .unc_blk_o, .word_long_o, .err_stat_o,
    .dec_stat_o, .irq_no(dec_irq_no), .done_o(dec_done)
  );

  assign hdr_min_o   = hdr[0];
  assign hdr_sec_o   = hdr[1];
  assign hdr_frm_o   = hdr[2];
  assign hdr_mode_o  = hdr[3];
  assign ill_sync_o  = flags.ill_sync;
  assign no_sync_o   = flags.no_sync;
  assign long_blk_o  = flags.long_blk;
  assign short_blk_o = flags.short_blk;
endmodule

// File: rtl/cdsf_checker.sv
module cdsf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bnd,
  input logic       dec_done,
  input logic       irq_ack_i,
  input logic       dec_irq_no,
  input logic       ill_sync_o,
  input logic       no_sync_o,
  input logic       long_blk_o,
  input logic       short_blk_o,
  input logic       crc_ok_o,
  input logic       unc_blk_o,
  input logic       word_long_o,
  input logic [7:0] err_stat_o,
  input logic [7:0] dec_stat_o
);
  AST_BND_RELEASES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> dec_irq_no); // R6
  AST_BND_CLEARS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> !(long_blk_o || short_blk_o || crc_ok_o || unc_blk_o || word_long_o)); // R6
  AST_SYNC_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(no_sync_o && ill_sync_o)); // R3
  AST_PASS_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_o |-> !(no_sync_o || ill_sync_o)); // R9
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_ok_o && unc_blk_o)); // R10
  AST_STAT_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_long_o |-> ((err_stat_o == 8'h00 && dec_stat_o == 8'h90) ||
                     (err_stat_o == 8'hFF && dec_stat_o == 8'hF2))); // R10
  AST_DONE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_done |=> (word_long_o && !dec_irq_no)); // R11
  AST_ACK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !dec_done) |=> dec_irq_no); // R12
endmodule

bind cd_sync_framer cdsf_checker u_cdsf_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bnd(bnd), .dec_done(dec_done),
  .irq_ack_i(irq_ack_i), .dec_irq_no(dec_irq_no), .ill_sync_o(ill_sync_o),
  .no_sync_o(no_sync_o), .long_blk_o(long_blk_o), .short_blk_o(short_blk_o),
  .crc_ok_o(crc_ok_o), .unc_blk_o(unc_blk_o), .word_long_o(word_long_o),
  .err_stat_o(err_stat_o), .dec_stat_o(dec_stat_o)
);

// File: tb/tb_cd_sync_framer.sv
`timescale 1ns/1ps
module tb_cd_sync_framer;
  localparam int DLY = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic vld = 1'b0, dec_en = 1'b1, wr_req = 1'b0, ins_en = 1'b0, rpt_en = 1'b1, ack = 1'b0;
  logic [7:0] hmin, hsec, hfrm, hmode, estat, dstat;
  logic ill, nos, lng, sht, crc, unc, wl, irq_n;

  int n_vec = 0, n_err = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  cd_sync_framer #(.DEC_DELAY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_i), .byte_vld_i(vld),
    .dec_en_i(dec_en), .wr_req_i(wr_req), .sync_ins_en_i(ins_en),
    .rpt_en_i(rpt_en), .irq_ack_i(ack),
    .hdr_min_o(hmin), .hdr_sec_o(hsec), .hdr_frm_o(hfrm), .hdr_mode_o(hmode),
    .ill_sync_o(ill), .no_sync_o(nos), .long_blk_o(lng), .short_blk_o(sht),
    .crc_ok_o(crc), .unc_blk_o(unc), .word_long_o(wl),
    .err_stat_o(estat), .dec_stat_o(dstat), .dec_irq_no(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_pos, m_match, m_tmr, m_hdr[4];
  int m_ill, m_nos, m_lng, m_sht, m_crc, m_unc, m_wl, m_es, m_ds, m_irq;

  function automatic bit bcd_ok(int v, int lim);
    return (v < lim) && ((v % 16) < 10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_match = 0; m_tmr = 0;
      foreach (m_hdr[i]) m_hdr[i] = 0;
      m_ill = 0; m_nos = 0; m_lng = 0; m_sht = 0;
      m_crc = 0; m_unc = 0; m_wl = 0; m_es = 0; m_ds = 0; m_irq = 1;
    end else begin
      bit matched, det, ign, ins, bnd, fin, ok;
      int expb;
      matched = vld && m_match == 11 && byte_i == 8'h00;
      det = matched && (m_pos % 4 == 3);
      ign = matched && !det;
      ins = vld && ins_en && m_pos == 2351;
      bnd = det || ins;
      fin = !bnd && m_tmr == 1;
      if (!bnd && m_tmr > 0) m_tmr--;
      if (fin) begin
        ok = bcd_ok(m_hdr[0], 'h74) && bcd_ok(m_hdr[1], 'h60) && bcd_ok(m_hdr[2], 'h75)
             && m_hdr[3] < 3 && !m_nos && !m_ill;
        m_es = ok ? 'h00 : 'hFF;
        m_ds = ok ? 'h90 : 'hF2;
        if (rpt_en) begin if (ok) m_crc = 1; else m_unc = 1; end
        m_wl = 1; m_irq = 0;
      end else if (ack) m_irq = 1;
      if (vld) begin
        if (dec_en && !wr_req && m_pos < 4) m_hdr[m_pos] = byte_i;
        expb = (m_match == 0 || m_match == 11) ? 'h00 : 'hFF;
        if (byte_i == expb) m_match = (m_match == 11) ? 1 : m_match + 1;
        else m_match = (byte_i == 8'h00) ? 1 : 0;
        if (bnd) begin
          m_ill = det && m_pos != 2351;
          m_nos = ins && !det && !ign;
          m_lng = 0; m_sht = 0; m_crc = 0; m_unc = 0; m_wl = 0; m_irq = 1;
          m_tmr = dec_en ? DLY : 0;
          m_pos = 0;
        end else begin
          if (ign) m_sht = 1;
          if (m_pos == 2351) m_lng = 1;
          m_pos = (m_pos + 1) % 4096;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R8 hdr_min", hmin, m_hdr[0]);
      check("R8 hdr_sec", hsec, m_hdr[1]);
      check("R8 hdr_frm", hfrm, m_hdr[2]);
      check("R8 hdr_mode", hmode, m_hdr[3]);
      check("R4 ill_sync", ill, m_ill);
      check("R3 no_sync", nos, m_nos);
      check("R5 long_blk", lng, m_lng);
      check("R5 short_blk", sht, m_sht);
      check("R10 crc_ok", crc, m_crc);
      check("R10 unc_blk", unc, m_unc);
      check("R10 err_stat", estat, m_es);
      check("R10 dec_stat", dstat, m_ds);
      check("R11 word_long", wl, m_wl);
      check("R12 dec_irq_n", irq_n, m_irq);
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_i = b; vld = 1'b1;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); vld = 1'b0; end
  endtask
  task automatic send_sync(input logic [7:0] last);
    put(8'h00);
    for (int i = 0; i < 10; i++) put(8'hFF);
    put(last);
  endtask
  task automatic send_body(input logic [7:0] a, b, c, d, input int ndata);
    put(a); put(b); put(c); put(d);
    for (int i = 0; i < ndata; i++) begin
      put(8'h5A);
      if (i == 100) idle(3);
    end
    idle(2);
  endtask
  function automatic logic [7:0] fil(int j);
    return 8'(8'h20 + (j % 97));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("reset irq", irq_n, 1);
    check("reset flags", {ill, nos, lng, sht, crc, unc, wl}, 0);
    check("reset hdr", {hmin, hsec, hfrm, hmode}, 0);
    rst_n = 1'b1;
    idle(3);
    // first sync at position 11: misplaced
    send_sync(8'h00); send_body(8'h00, 8'h02, 8'h00, 8'h01, 2336);
    check("R4 first sync misplaced", ill, 1);
    check("R9 fail on ill sync", unc, 1);
    // clean sector, R1 boundary at 2351
    send_sync(8'h00); send_body(8'h00, 8'h02, 8'h00, 8'h01, 2336);
    check("R1 clean sync", ill, 0);
    check("R9 pass", crc, 1);
    check("R10 pass codes", {estat, dstat}, 16'h0090);
    check("R11 irq low", irq_n, 0);
    check("R7 idle gaps keep alignment", hsec, 8'h02);
    // range limits
    send_sync(8'h00); send_body(8'h74, 8'h00, 8'h00, 8'h00, 2336);
    check("R9 minute limit", unc, 1);
    check("R10 fail codes", {estat, dstat}, 16'hFFF2);
    send_sync(8'h00); send_body(8'h10, 8'h5A, 8'h00, 8'h00, 2336);
    check("R9 second nibble", unc, 1);
    send_sync(8'h00); send_body(8'h10, 8'h10, 8'h10, 8'h03, 2336);
    check("R9 mode limit", unc, 1);
    send_sync(8'h00); send_body(8'h73, 8'h59, 8'h74, 8'h02, 2336);
    check("R9 max valid", crc, 1);
    // reporting disabled
    rpt_en = 1'b0;
    send_sync(8'h00); send_body(8'h01, 8'h02, 8'h03, 8'h01, 2336);
    check("R10 no crc when report off", crc, 0);
    check("R10 codes still set", {estat, dstat}, 16'h0090);
    rpt_en = 1'b1;
    // acknowledge
    send_sync(8'h00); send_body(8'h01, 8'h02, 8'h03, 8'h01, 2336);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R12 ack releases irq", irq_n, 1);
    // insertion with broken sync
    ins_en = 1'b1;
    send_sync(8'h01); send_body(8'h01, 8'h02, 8'h03, 8'h01, 2336);
    check("R2 inserted boundary captured hdr", hmin, 8'h01);
    check("R3 no sync flagged", nos, 1);
    check("R9 fail on no sync", unc, 1);
    send_sync(8'h00); send_body(8'h01, 8'h02, 8'h04, 8'h01, 2332);
    check("R2 real sync at insert point", {nos, ill, crc}, 1);
    ins_en = 1'b0;
    // early sync
    send_sync(8'h00); send_body(8'h01, 8'h02, 8'h05, 8'h01, 2335);
    check("R4 early sync", ill, 1);
    // unaligned sync at 2350
    send_sync(8'h00); idle(2);
    check("R5 short block", sht, 1);
    check("R6 flags before next bnd", ill, 1);
    for (int k = 0; k < 5; k++) put(8'h33);
    idle(2);
    check("R5 long block", lng, 1);
    send_sync(8'h00); idle(2);
    check("R6 boundary clears long/short", {lng, sht}, 0);
    // wrap of the position
    for (int j = 0; j < 4100; j++) put(fil(j));
    idle(2);
    check("R7 wrap recaptures header", hmin, fil(4096));
    check("R7 wrap recaptures mode", hmode, fil(4099));
    // decoder disabled
    dec_en = 1'b0;
    send_sync(8'h00); send_body(8'h11, 8'h22, 8'h33, 8'h01, 2336);
    check("R11 no decode when disabled", irq_n, 1);
    check("R8 no capture when disabled", hmin, fil(4096));
    // write request: decode but no capture
    dec_en = 1'b1; wr_req = 1'b1;
    send_sync(8'h00); send_body(8'h11, 8'h22, 8'h33, 8'h01, 2336);
    check("R8 no capture with write req", hmin, fil(4096));
    check("R11 decode with write req", irq_n, 0);
    check("R9 stale mode fails", unc, 1);
    idle(4);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule